// File: doc/BRIEF.md
# Single-Enable External Interrupt Controller

This block holds the processor-side interrupt state for a CPU that has one global interrupt enable bit and no priority levels. At each instruction boundary the fetch logic raises a strobe. If a request is pending and interrupts are enabled at that moment, the block performs an entry, which is indivisible. It stores the current program counter and a 16-bit cause word from the source, clears the enable bit, and sends the CPU a new program counter and a load strobe. It also pulses an acknowledge back to the source for one cycle.

The new program counter is a jump target built from an 8-bit code that the source supplies. The code sits in bits 11..4 and every other bit is zero, so each source code selects a 16-byte slot in low memory. The executing instruction drives command strobes into the block:
- return from handler, which reloads the PC from the saved copy and re-enables interrupts in one step;
- enable and disable of the interrupt enable bit;
- save, which presents the saved cause and saved PC as two register-width words;
- restore, which loads the saved cause and saved PC from two register-width words.

Arbitration among several sources happens outside the block. All other context saving is left to software.

Top module: `irqc_top`

## Requirements
- R1: An entry occurs on a clock edge where `fetch_boundary`, `irq_req` and `int_enable` are all 1. In the following cycle `irq_ack` and `pc_load` are 1. In any other case `irq_ack` is 0 in the following cycle.
- R2: On entry, `epc` takes the value of `pc_now`, `einfo` takes the value of `irq_info`, and `int_enable` becomes 0, all at the same edge.
- R3: On an entry, `pc_next` equals the sampled `irq_code` placed in bits 11..4, with bits 31..12 and 3..0 zero. For example, code 0xA5 gives 0x0000_0A50. When `pc_load` is 0, `pc_next` is 0.
- R4: `irq_ack` is high for exactly one cycle per entry.
- R5: When `op_rfi` is sampled without `op_restore` and without an entry, the next cycle shows `pc_load` = 1, `pc_next` equal to `epc` as it was before that edge, and `int_enable` = 1.
- R6: `op_enable` sets `int_enable` to 1 and `op_disable` clears it. If both are sampled together, disable wins. `op_rfi` overrides both.
- R7: Synchronous active-high `rst` clears `int_enable`, `epc`, `einfo`, `irq_ack`, `pc_load`, `pc_next` and `op_illegal`.
- R8: While `op_save` is 1, `save_info_out` equals `einfo` zero-extended to 32 bits and `save_pc_out` equals `epc`. Both show the stored values before any update at the coming edge. While `op_save` is 0, both outputs are 0.
- R9: A sampled `op_restore` loads `einfo` from `restore_info[15:0]` and `epc` from `restore_pc`.
- R10: If `op_rfi` and `op_restore` are sampled in the same cycle, `op_illegal` is 1 in the next cycle and both commands are ignored: `epc`, `einfo` and `pc_load` are unchanged by them, and `int_enable` is not set by the return.
- R11: An entry takes precedence over every command sampled in the same cycle. Return, restore, enable and disable are then ignored.
- R12: If `irq_req` stays high after an entry, no further entry occurs until `int_enable` has been set to 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request from the external source |
| irq_code | input | 8 | Source code used to build the jump target |
| irq_info | input | 16 | Cause word from the source |
| pc_now | input | 32 | Program counter at the current instruction boundary |
| fetch_boundary | input | 1 | Strobe marking the start of an instruction fetch |
| op_rfi | input | 1 | Return-from-handler command |
| op_enable | input | 1 | Enable-interrupts command |
| op_disable | input | 1 | Disable-interrupts command |
| op_save | input | 1 | Save command, presents the saved state |
| op_restore | input | 1 | Restore command |
| restore_info | input | 32 | Restore source word for the cause (low 16 bits used) |
| restore_pc | input | 32 | Restore source word for the saved PC |
| irq_ack | output | 1 | One-cycle acknowledge to the source |
| pc_load | output | 1 | Strobe telling the CPU to load `pc_next` |
| pc_next | output | 32 | New program counter value |
| int_enable | output | 1 | Interrupt enable bit |
| epc | output | 32 | Saved program counter |
| einfo | output | 16 | Saved cause word |
| save_info_out | output | 32 | Saved cause, zero-extended, while saving |
| save_pc_out | output | 32 | Saved PC while saving |
| op_illegal | output | 1 | Flag for a return and a restore issued in the same cycle |

## Verification
Two collisions are the focus. The first is an entry that lands in the same cycle as a return, restore or enable. The second is a return that lands in the same cycle as a restore. The bench forces each collision by raising the boundary strobe with a pending request while also pulsing the commands, and by pulsing return and restore together. It then checks at the ports that only the winning action changed `epc`, `einfo`, `int_enable` and the PC load. A behavioural model run in step with the design also exposes these collisions across a long random stream of inputs.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned IRQC_PC_W    = 32;
    localparam int unsigned IRQC_INFO_W  = 16;
    localparam int unsigned IRQC_CODE_W  = 8;
    localparam int unsigned IRQC_VEC_LSB = 4;

    // Resolved actions for one clock edge
    typedef struct packed {
        logic take;      // interrupt entry
        logic rfi;       // return from handler, effective
        logic restore;   // restore of saved state, effective
        logic set_ie;    // enable bit goes to 1
        logic clr_ie;    // enable bit goes to 0
        logic clash;     // return and restore together
    } irqc_act_t;

    // Precedence: entry, then the return/restore clash, then return over
    // enable/disable, then disable over enable.
    function automatic irqc_act_t irqc_resolve(
        input logic boundary,
        input logic req,
        input logic ie,
        input logic rfi,
        input logic restore,
        input logic en,
        input logic dis
    );
        irqc_act_t a;
        a.take    = boundary & req & ie;
        a.clash   = rfi & restore;
        a.rfi     = ~a.take & rfi & ~a.clash;
        a.restore = ~a.take & restore & ~a.clash;
        a.set_ie  = ~a.take & (a.rfi | (en & ~dis));
        a.clr_ie  = a.take | (dis & ~a.rfi);
        return a;
    endfunction

endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic      fetch_boundary,
    input  logic      irq_req,
    input  logic      ie,
    input  logic      op_rfi,
    input  logic      op_restore,
    input  logic      op_enable,
    input  logic      op_disable,
    output irqc_act_t act
);

    always_comb begin
        act = irqc_resolve(fetch_boundary, irq_req, ie,
                           op_rfi, op_restore, op_enable, op_disable);
    end

endmodule

// File: rtl/irqc_ctx.sv
module irqc_ctx
    import irqc_pkg::*;
#(
    parameter int unsigned PC_W   = IRQC_PC_W,
    parameter int unsigned INFO_W = IRQC_INFO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  irqc_act_t         act,
    input  logic [PC_W-1:0]   pc_now,
    input  logic [INFO_W-1:0] irq_info,
    input  logic [PC_W-1:0]   restore_pc,
    input  logic [INFO_W-1:0] restore_info,
    output logic              ie,
    output logic [PC_W-1:0]   epc,
    output logic [INFO_W-1:0] einfo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie <= 1'b0;
        end else if (act.clr_ie) begin
            ie <= 1'b0;
        end else if (act.set_ie) begin
            ie <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc   <= '0;
            einfo <= '0;
        end else if (act.take) begin
            epc   <= pc_now;
            einfo <= irq_info;
        end else if (act.restore) begin
            epc   <= restore_pc;
            einfo <= restore_info;
        end
    end

endmodule

// File: rtl/irqc_redirect.sv
module irqc_redirect
    import irqc_pkg::*;
#(
    parameter int unsigned PC_W    = IRQC_PC_W,
    parameter int unsigned CODE_W  = IRQC_CODE_W,
    parameter int unsigned VEC_LSB = IRQC_VEC_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  irqc_act_t         act,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [PC_W-1:0]   epc,
    output logic              irq_ack,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_next,
    output logic              op_illegal
);

    localparam int unsigned VEC_HI = VEC_LSB + CODE_W - 1;

    logic [PC_W-1:0] vec;

    generate
        if (VEC_LSB == 0) begin : g_vec_low
            assign vec = {{(PC_W-CODE_W){1'b0}}, irq_code};
        end else begin : g_vec_mid
            assign vec = {{(PC_W-VEC_HI-1){1'b0}}, irq_code, {VEC_LSB{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_ack    <= 1'b0;
            pc_load    <= 1'b0;
            pc_next    <= '0;
            op_illegal <= 1'b0;
        end else begin
            irq_ack    <= act.take;
            pc_load    <= act.take | act.rfi;
            op_illegal <= act.clash;
            if (act.take) begin
                pc_next <= vec;
            end else if (act.rfi) begin
                pc_next <= epc;
            end else begin
                pc_next <= '0;
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned PC_W    = IRQC_PC_W,
    parameter int unsigned INFO_W  = IRQC_INFO_W,
    parameter int unsigned CODE_W  = IRQC_CODE_W,
    parameter int unsigned VEC_LSB = IRQC_VEC_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [INFO_W-1:0] irq_info,
    input  logic [PC_W-1:0]   pc_now,
    input  logic              fetch_boundary,
    input  logic              op_rfi,
    input  logic              op_enable,
    input  logic              op_disable,
    input  logic              op_save,
    input  logic              op_restore,
    input  logic [PC_W-1:0]   restore_info,
    input  logic [PC_W-1:0]   restore_pc,
    output logic              irq_ack,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_next,
    output logic              int_enable,
    output logic [PC_W-1:0]   epc,
    output logic [INFO_W-1:0] einfo,
    output logic [PC_W-1:0]   save_info_out,
    output logic [PC_W-1:0]   save_pc_out,
    output logic              op_illegal
);

    irqc_act_t         act;
    logic [PC_W-1:0]   info_wide;
    logic [PC_W-1:0]   restore_unused;

    irqc_arbiter u_arb (
        .fetch_boundary (fetch_boundary),
        .irq_req        (irq_req),
        .ie             (int_enable),
        .op_rfi         (op_rfi),
        .op_restore     (op_restore),
        .op_enable      (op_enable),
        .op_disable     (op_disable),
        .act            (act)
    );

    irqc_ctx #(.PC_W(PC_W), .INFO_W(INFO_W)) u_ctx (
        .clk          (clk),
        .rst          (rst),
        .act          (act),
        .pc_now       (pc_now),
        .irq_info     (irq_info),
        .restore_pc   (restore_pc),
        .restore_info (restore_info[INFO_W-1:0]),
        .ie           (int_enable),
        .epc          (epc),
        .einfo        (einfo)
    );

    irqc_redirect #(.PC_W(PC_W), .CODE_W(CODE_W), .VEC_LSB(VEC_LSB)) u_redir (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .irq_code   (irq_code),
        .epc        (epc),
        .irq_ack    (irq_ack),
        .pc_load    (pc_load),
        .pc_next    (pc_next),
        .op_illegal (op_illegal)
    );

    generate
        if (INFO_W < PC_W) begin : g_pad
            assign info_wide      = {{(PC_W-INFO_W){1'b0}}, einfo};
            assign restore_unused = {restore_info[PC_W-1:INFO_W], {INFO_W{1'b0}}};
        end else begin : g_nopad
            assign info_wide      = einfo[PC_W-1:0];
            assign restore_unused = '0;
        end
    endgenerate

    always_comb begin
        save_info_out = op_save ? info_wide : '0;
        save_pc_out   = op_save ? epc : '0;
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned INFO_W  = 16,
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned VEC_LSB = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_req,
    input logic [CODE_W-1:0] irq_code,
    input logic [INFO_W-1:0] irq_info,
    input logic [PC_W-1:0]   pc_now,
    input logic              fetch_boundary,
    input logic              op_rfi,
    input logic              op_restore,
    input logic              irq_ack,
    input logic              pc_load,
    input logic [PC_W-1:0]   pc_next,
    input logic              int_enable,
    input logic [PC_W-1:0]   epc,
    input logic [INFO_W-1:0] einfo,
    input logic              op_illegal
);

    logic entry_cond;
    assign entry_cond = fetch_boundary && irq_req && int_enable;

    p_entry_r1: assert property (@(posedge clk) disable iff (rst)
        entry_cond |=> (irq_ack && pc_load));

    p_no_entry_r1: assert property (@(posedge clk) disable iff (rst)
        !entry_cond |=> !irq_ack);

    p_entry_save_r2: assert property (@(posedge clk) disable iff (rst)
        entry_cond |=> (!int_enable && epc == $past(pc_now) && einfo == $past(irq_info)));

    p_vector_r3: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (pc_next == (PC_W'($past(irq_code)) << VEC_LSB)));

    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    p_rfi_r5: assert property (@(posedge clk) disable iff (rst)
        (op_rfi && !op_restore && !entry_cond) |=>
            (pc_load && int_enable && pc_next == $past(epc)));

    p_reset_r7: assert property (@(posedge clk)
        rst |=> (!int_enable && !irq_ack && !pc_load && epc == '0 && einfo == '0));

    p_clash_r10: assert property (@(posedge clk) disable iff (rst)
        (op_rfi && op_restore && !entry_cond) |=>
            (op_illegal && !pc_load && $stable(epc) && $stable(einfo)));

endmodule

bind irqc_top irqc_checker #(
    .PC_W(PC_W), .INFO_W(INFO_W), .CODE_W(CODE_W), .VEC_LSB(VEC_LSB)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .irq_req        (irq_req),
    .irq_code       (irq_code),
    .irq_info       (irq_info),
    .pc_now         (pc_now),
    .fetch_boundary (fetch_boundary),
    .op_rfi         (op_rfi),
    .op_restore     (op_restore),
    .irq_ack        (irq_ack),
    .pc_load        (pc_load),
    .pc_next        (pc_next),
    .int_enable     (int_enable),
    .epc            (epc),
    .einfo          (einfo),
    .op_illegal     (op_illegal)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_code = '0;
    logic [15:0] irq_info = '0;
    logic [31:0] pc_now = '0;
    logic        fetch_boundary = 1'b0;
    logic        op_rfi = 1'b0, op_enable = 1'b0, op_disable = 1'b0;
    logic        op_save = 1'b0, op_restore = 1'b0;
    logic [31:0] restore_info = '0, restore_pc = '0;
    logic        irq_ack, pc_load, int_enable, op_illegal;
    logic [31:0] pc_next, epc, save_info_out, save_pc_out;
    logic [15:0] einfo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irqc_top uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_code(irq_code),
        .irq_info(irq_info), .pc_now(pc_now), .fetch_boundary(fetch_boundary),
        .op_rfi(op_rfi), .op_enable(op_enable), .op_disable(op_disable),
        .op_save(op_save), .op_restore(op_restore), .restore_info(restore_info),
        .restore_pc(restore_pc), .irq_ack(irq_ack), .pc_load(pc_load),
        .pc_next(pc_next), .int_enable(int_enable), .epc(epc), .einfo(einfo),
        .save_info_out(save_info_out), .save_pc_out(save_pc_out),
        .op_illegal(op_illegal)
    );

    // Behavioural reference model
    logic        m_ie = 0, m_ack = 0, m_load = 0, m_ill = 0;
    logic [31:0] m_epc = 0, m_pcn = 0;
    logic [15:0] m_ii = 0;

    always @(posedge clk) begin
        logic take, clash, rfi_ok, rest_ok;
        logic [31:0] old_epc;
        if (rst) begin
            m_ie = 0; m_ack = 0; m_load = 0; m_ill = 0;
            m_epc = 0; m_pcn = 0; m_ii = 0;
        end else begin
            old_epc = m_epc;
            take    = fetch_boundary && irq_req && m_ie;
            clash   = op_rfi && op_restore;
            rfi_ok  = !take && op_rfi && !clash;
            rest_ok = !take && op_restore && !clash;
            m_ack   = take;
            m_ill   = clash;
            m_load  = take || rfi_ok;
            if (take)        m_pcn = {20'h0, irq_code, 4'h0};
            else if (rfi_ok) m_pcn = old_epc;
            else             m_pcn = 0;
            if (take)                          m_ie = 0;
            else if (rfi_ok)                   m_ie = 1;
            else if (op_disable)               m_ie = 0;
            else if (op_enable)                m_ie = 1;
            if (take) begin
                m_epc = pc_now; m_ii = irq_info;
            end else if (rest_ok) begin
                m_epc = restore_pc; m_ii = restore_info[15:0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R1/R4 irq_ack", {31'b0, irq_ack}, {31'b0, m_ack});
            chk("R1/R5 pc_load", {31'b0, pc_load}, {31'b0, m_load});
            chk("R3/R5 pc_next", pc_next, m_pcn);
            chk("R6 int_enable", {31'b0, int_enable}, {31'b0, m_ie});
            chk("R2/R9 epc", epc, m_epc);
            chk("R2/R9 einfo", {16'b0, einfo}, {16'b0, m_ii});
            chk("R10 op_illegal", {31'b0, op_illegal}, {31'b0, m_ill});
            chk("R8 save_info_out", save_info_out, op_save ? {16'b0, m_ii} : 32'b0);
            chk("R8 save_pc_out", save_pc_out, op_save ? m_epc : 32'b0);
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        fetch_boundary = 0; op_rfi = 0; op_enable = 0; op_disable = 0;
        op_save = 0; op_restore = 0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R7: reset state
        chk("R7 reset int_enable", {31'b0, int_enable}, 32'd0);
        chk("R7 reset epc", epc, 32'd0);
        rst = 0;
        tick();

        // R12/R1: request while disabled gives no entry
        irq_req = 1; irq_code = 8'hA5; irq_info = 16'h1234; pc_now = 32'h100;
        fetch_boundary = 1;
        tick(); tick();
        chk("R1 no entry while disabled", {31'b0, irq_ack}, 32'd0);

        // R6: enable, then entry
        idle(); op_enable = 1; tick();
        idle(); tick();
        chk("R6 enable", {31'b0, int_enable}, 32'd1);
        fetch_boundary = 1; tick();
        idle(); pc_now = 32'h104; fetch_boundary = 1;
        chk("R3 vector 0xA5", pc_next, 32'h0000_0A50);
        chk("R2 epc saved", epc, 32'h100);
        chk("R2 ie cleared", {31'b0, int_enable}, 32'd0);
        // R12: request held, boundaries continue, no second entry
        repeat (4) tick();
        chk("R12 no re-entry", {31'b0, irq_ack}, 32'd0);
        chk("R4 ack dropped", {31'b0, irq_ack}, 32'd0);
        idle(); irq_req = 0;

        // R8: save presents state
        op_save = 1; #1;
        chk("R8 save info", save_info_out, 32'h0000_1234);
        chk("R8 save pc", save_pc_out, 32'h100);
        // R9 with R8: restore in same cycle as save shows old values
        op_restore = 1; restore_info = 32'hFFFF_BEEF; restore_pc = 32'h2000; #1;
        chk("R8 save shows pre-restore pc", save_pc_out, 32'h100);
        tick();
        idle();
        chk("R9 restore pc", epc, 32'h2000);
        chk("R9 restore info low half", {16'b0, einfo}, 32'h0000_BEEF);

        // R10: return and restore together
        op_rfi = 1; op_restore = 1; restore_pc = 32'h3000; tick();
        idle();
        chk("R10 illegal flag", {31'b0, op_illegal}, 32'd1);
        chk("R10 epc kept", epc, 32'h2000);
        chk("R10 no load", {31'b0, pc_load}, 32'd0);

        // R5: return from handler
        op_rfi = 1; tick();
        idle();
        chk("R5 rfi target", pc_next, 32'h2000);
        chk("R5 rfi ie", {31'b0, int_enable}, 32'd1);

        // R6: disable wins over enable
        op_enable = 1; op_disable = 1; tick();
        idle();
        chk("R6 disable wins", {31'b0, int_enable}, 32'd0);
        op_enable = 1; tick(); idle();

        // R11: entry beats restore/return in the same cycle
        irq_req = 1; irq_code = 8'hFF; irq_info = 16'h0F0F; pc_now = 32'h400;
        fetch_boundary = 1; op_restore = 1; op_rfi = 0; restore_pc = 32'h5555;
        op_enable = 1; tick();
        idle(); irq_req = 0;
        chk("R11 entry wins epc", epc, 32'h400);
        chk("R11 ie stays clear", {31'b0, int_enable}, 32'd0);
        chk("R3 vector 0xFF", pc_next, 32'h0000_0FF0);

        // R3: code zero
        op_enable = 1; tick(); idle();
        irq_req = 1; irq_code = 8'h00; fetch_boundary = 1; tick();
        idle(); irq_req = 0;
        chk("R3 vector 0x00", pc_next, 32'h0);
        chk("R1 entry load", {31'b0, pc_load}, 32'd1);

        // Random stream compared with the model each cycle (R1..R12)
        for (int i = 0; i < 3000; i++) begin
            irq_req        = ($urandom % 3) == 0;
            irq_code       = 8'($urandom);
            irq_info       = 16'($urandom);
            pc_now         = $urandom;
            fetch_boundary = ($urandom % 4) == 0;
            op_rfi         = ($urandom % 8) == 0;
            op_enable      = ($urandom % 6) == 0;
            op_disable     = ($urandom % 10) == 0;
            op_save        = ($urandom % 5) == 0;
            op_restore     = ($urandom % 8) == 0;
            restore_info   = $urandom;
            restore_pc     = $urandom;
            rst            = ($urandom % 500) == 0;
            tick();
        end
        rst = 0; idle();
        tick();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule